// File: doc/BRIEF.md
# Peripheral Ready Status Tracker

This block keeps one readiness flag for each of several peripheral instances and reports them together in a single read-only status word. Three control bits steer each instance: a power enable, a run-clock enable and a software reset. Two completion inputs come from the sequencing logic: power-done and reset-done. Certain changes on the control bits mean that the instance cannot be trusted for a while. When the tracker sees one, it drops that instance's flag. The flag stays low until the instance is powered, clocked, out of software reset, and both completion inputs report that their sequences have finished.

Each control bit is compared against a copy of itself taken one cycle earlier. A rising edge on the power enable or on the software reset clears the flag. A change in either direction on the clock enable also clears it. A falling edge on power or reset does not clear the flag. A clear and a completion in the same cycle resolve in favour of the clear.

Software reads the flags over a plain read port. Data returns on the cycle after the read request. Any address other than the status address reads zero.

Top module: `periph_ready_tracker`

## Requirements
- R1: A read with `rdEn` high and `addr` equal to `STATUS_ADDR` (default 0) returns, on the next cycle, a word in which bit n is the ready flag of instance n. Bits `DATA_W-1:NUM_INST` read 0. A read with `rdEn` low, or with any other address, returns all zeros.
- R2: After reset every ready flag is 0, so the status word reads 0x00000000.
- R3: A 0-to-1 change of `pwrEn[n]` clears ready flag n at the clock edge that first samples the new value. A 1-to-0 change of `pwrEn[n]` clears nothing.
- R4: Any change of `clkEn[n]`, rising or falling, clears ready flag n at the clock edge that first samples it.
- R5: A 0-to-1 change of `swRst[n]` clears ready flag n at the clock edge that first samples it. A 1-to-0 change clears nothing.
- R6: Ready flag n becomes 1 only at an edge where `pwrEn[n]`, `clkEn[n]`, `pwrDone[n]` and `rstDone[n]` are all 1 and `swRst[n]` is 0.
- R7: If a clearing change and the full set condition coincide at one edge, the flag is 0 after that edge. It can become 1 at the following edge at the earliest.
- R8: Events on one instance never alter the ready flag of any other instance.
- R9: When no clearing change is seen and the set condition is not met, a ready flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Status clock |
| rstN | input | 1 | Active-low synchronous reset |
| pwrEn | input | NUM_INST | Per-instance power enable |
| clkEn | input | NUM_INST | Per-instance run-clock enable |
| swRst | input | NUM_INST | Per-instance software reset request |
| pwrDone | input | NUM_INST | Per-instance power sequence finished |
| rstDone | input | NUM_INST | Per-instance internal reset finished |
| rdEn | input | 1 | Read request |
| addr | input | ADDR_W | Read address |
| rdData | output | DATA_W | Read data, valid the cycle after the request |

## Verification
The bench builds the tracker with its default values: eight instances, a 32-bit data word, a 4-bit address and the status word at address 0. With these values, 24 reserved bits sit above the flags, and every one of them must read zero. There are also enough instances to exercise power, clock and reset events on separate instances while the other flags stay set. Because read data is registered, a read issued right after a clearing event captures the flag between the clear and the next possible set. This makes the priority of the clear over a completion in the same cycle visible at the ports.

// File: rtl/prt_pkg.sv
package prt_pkg;
  // per-instance strobes from the event control to the status datapath
  typedef struct packed {
    logic clearEv;  // a readiness-invalidating change was seen this cycle
    logic setOk;    // every readiness condition holds this cycle
  } instStrobe_t;
endpackage

// File: rtl/prt_event_ctrl.sv
module prt_event_ctrl
  import prt_pkg::*;
#(
  parameter int unsigned NUM_INST = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_INST-1:0]           pwrEn,
  input  logic [NUM_INST-1:0]           clkEn,
  input  logic [NUM_INST-1:0]           swRst,
  input  logic [NUM_INST-1:0]           pwrDone,
  input  logic [NUM_INST-1:0]           rstDone,
  output instStrobe_t [NUM_INST-1:0]    strobes
);

  for (genvar gi = 0; gi < NUM_INST; gi++) begin : g_inst
    logic pwrPrev, clkPrev, rstPrev;
    logic pwrRise, clkFlip, rstRise;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pwrPrev <= 1'b0;
        clkPrev <= 1'b0;
        rstPrev <= 1'b0;
      end else begin
        pwrPrev <= pwrEn[gi];
        clkPrev <= clkEn[gi];
        rstPrev <= swRst[gi];
      end
    end

    always_comb begin
      pwrRise = pwrEn[gi] & ~pwrPrev;
      clkFlip = clkEn[gi] ^ clkPrev;
      rstRise = swRst[gi] & ~rstPrev;
      strobes[gi].clearEv = pwrRise | clkFlip | rstRise;
      strobes[gi].setOk   = pwrEn[gi] & clkEn[gi] & ~swRst[gi]
                          & pwrDone[gi] & rstDone[gi];
    end
  end

endmodule

// File: rtl/prt_status_path.sv
module prt_status_path
  import prt_pkg::*;
#(
  parameter int unsigned NUM_INST    = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned STATUS_ADDR = 0
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  instStrobe_t [NUM_INST-1:0] strobes,
  input  logic                       rdEn,
  input  logic [ADDR_W-1:0]          addr,
  output logic [NUM_INST-1:0]        readyVec,
  output logic [DATA_W-1:0]          rdData
);

  localparam logic [ADDR_W-1:0] STATUS_SEL = ADDR_W'(STATUS_ADDR);

  logic [DATA_W-1:0] statusWord;

  for (genvar gi = 0; gi < NUM_INST; gi++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN)                    readyVec[gi] <= 1'b0;
      else if (strobes[gi].clearEv) readyVec[gi] <= 1'b0;
      else if (strobes[gi].setOk)   readyVec[gi] <= 1'b1;
    end
  end

  // zero extension keeps reserved bits at 0
  assign statusWord = DATA_W'(readyVec);

  always_ff @(posedge clk) begin
    if (!rstN)                          rdData <= '0;
    else if (rdEn && addr == STATUS_SEL) rdData <= statusWord;
    else                                rdData <= '0;
  end

endmodule

// File: rtl/periph_ready_tracker.sv
module periph_ready_tracker
  import prt_pkg::*;
#(
  parameter int unsigned NUM_INST    = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned STATUS_ADDR = 0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_INST-1:0] pwrEn,
  input  logic [NUM_INST-1:0] clkEn,
  input  logic [NUM_INST-1:0] swRst,
  input  logic [NUM_INST-1:0] pwrDone,
  input  logic [NUM_INST-1:0] rstDone,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   addr,
  output logic [DATA_W-1:0]   rdData
);

  instStrobe_t [NUM_INST-1:0] strobes;
  logic [NUM_INST-1:0]        readyVec;

  prt_event_ctrl #(.NUM_INST(NUM_INST)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .pwrEn   (pwrEn),
    .clkEn   (clkEn),
    .swRst   (swRst),
    .pwrDone (pwrDone),
    .rstDone (rstDone),
    .strobes (strobes)
  );

  prt_status_path #(
    .NUM_INST    (NUM_INST),
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W),
    .STATUS_ADDR (STATUS_ADDR)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .rdEn     (rdEn),
    .addr     (addr),
    .readyVec (readyVec),
    .rdData   (rdData)
  );

endmodule

// File: rtl/prt_checker.sv
module prt_checker #(
  parameter int unsigned NUM_INST = 8,
  parameter int unsigned DATA_W   = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_INST-1:0] pwrEn,
  input logic [NUM_INST-1:0] clkEn,
  input logic [NUM_INST-1:0] swRst,
  input logic [NUM_INST-1:0] pwrDone,
  input logic [NUM_INST-1:0] rstDone,
  input logic [NUM_INST-1:0] readyVec,
  input logic [DATA_W-1:0]   rdData
);

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdData[DATA_W-1:NUM_INST] == '0); // R1

  for (genvar gi = 0; gi < NUM_INST; gi++) begin : g_chk
    AST_PWR_RISE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
      $rose(pwrEn[gi]) |=> !readyVec[gi]); // R3

    AST_CLK_CHANGE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(clkEn[gi]) |=> !readyVec[gi]); // R4

    AST_RST_RISE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
      $rose(swRst[gi]) |=> !readyVec[gi]); // R5

    AST_SET_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rstN)
      $rose(readyVec[gi]) |-> $past(pwrEn[gi] & clkEn[gi] & ~swRst[gi]
                                    & pwrDone[gi] & rstDone[gi])); // R6
  end

endmodule

bind periph_ready_tracker prt_checker #(
  .NUM_INST (NUM_INST),
  .DATA_W   (DATA_W)
) u_prtChecker (
  .clk      (clk),
  .rstN     (rstN),
  .pwrEn    (pwrEn),
  .clkEn    (clkEn),
  .swRst    (swRst),
  .pwrDone  (pwrDone),
  .rstDone  (rstDone),
  .readyVec (readyVec),
  .rdData   (rdData)
);

// File: tb/periph_ready_tracker_bench.sv
`timescale 1ns/1ps
module periph_ready_tracker_bench;

  localparam int unsigned NUM_INST = 8;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 4;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic [NUM_INST-1:0] pwrEn = '0, clkEn = '0, swRst = '0;
  logic [NUM_INST-1:0] pwrDone = '0, rstDone = '0;
  logic                rdEn = 1'b0;
  logic [ADDR_W-1:0]   addr = '0;
  logic [DATA_W-1:0]   rdData;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  periph_ready_tracker #(
    .NUM_INST(NUM_INST), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STATUS_ADDR(0)
  ) u_periph_ready_tracker (
    .clk(clk), .rstN(rstN), .pwrEn(pwrEn), .clkEn(clkEn), .swRst(swRst),
    .pwrDone(pwrDone), .rstDone(rstDone), .rdEn(rdEn), .addr(addr),
    .rdData(rdData)
  );

  task automatic check(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic readAt(input logic [ADDR_W-1:0] a, input logic en,
                        output logic [DATA_W-1:0] v);
    rdEn = en;
    addr = a;
    @(posedge clk);
    @(negedge clk);
    v = rdData;
    rdEn = 1'b0;
    addr = '0;
  endtask

  task automatic expectStatus(input string req, input logic [DATA_W-1:0] exp);
    logic [DATA_W-1:0] v;
    readAt('0, 1'b1, v);
    check(req, v, exp);
  endtask

  task automatic testReset();
    expectStatus("R2 reset value", 32'h0);
  endtask

  task automatic testClearWins();
    pwrEn[0] = 1'b1; clkEn[0] = 1'b1; pwrDone[0] = 1'b1; rstDone[0] = 1'b1;
    step(1);
    expectStatus("R7 clear beats completion", 32'h0000_0000);
    expectStatus("R7 set one edge later", 32'h0000_0001);
  endtask

  task automatic testBringUp();
    pwrEn[7:1] = '1; clkEn[7:1] = '1; swRst[3] = 1'b1;
    step(3);
    expectStatus("R6 no completion yet", 32'h0000_0001);
    pwrDone[7:1] = '1;
    step(2);
    expectStatus("R6 reset sequence pending", 32'h0000_0001);
    rstDone[7:1] = '1;
    step(2);
    expectStatus("R6 swRst still holds instance 3", 32'h0000_00F7);
    swRst[3] = 1'b0;
    step(1);
    expectStatus("R5 release of swRst does not clear", 32'h0000_00FF);
  endtask

  task automatic testClockToggle();
    clkEn[2] = 1'b0;
    step(1);
    expectStatus("R4 falling clkEn clears, R8 others kept", 32'h0000_00FB);
    step(3);
    expectStatus("R9 flag held low while clock off", 32'h0000_00FB);
    clkEn[2] = 1'b1;
    expectStatus("R4 rising clkEn seen as clear", 32'h0000_00FB);
    expectStatus("R4 no early set after clock change", 32'h0000_00FB);
    expectStatus("R6 set after clock stable", 32'h0000_00FF);
  endtask

  task automatic testSoftReset();
    swRst[5] = 1'b1;
    step(1);
    expectStatus("R5 swRst rise clears instance 5", 32'h0000_00DF);
    step(2);
    expectStatus("R6 held while swRst high", 32'h0000_00DF);
    swRst[5] = 1'b0;
    step(1);
    expectStatus("R5 ready after swRst release", 32'h0000_00FF);
  endtask

  task automatic testPowerEdges();
    pwrEn[4] = 1'b0;
    step(2);
    expectStatus("R3 power fall does not clear, R9 hold", 32'h0000_00FF);
    pwrEn[4] = 1'b1;
    step(1);
    expectStatus("R3 power rise clears instance 4", 32'h0000_00EF);
    expectStatus("R3 ready again after power rise", 32'h0000_00FF);
  endtask

  task automatic testReadPort();
    logic [DATA_W-1:0] v;
    readAt('0, 1'b0, v);
    check("R1 no read request reads zero", v, 32'h0);
    readAt(4'd1, 1'b1, v);
    check("R1 other address reads zero", v, 32'h0);
    readAt(4'd15, 1'b1, v);
    check("R1 top address reads zero", v, 32'h0);
    expectStatus("R1 status word with reserved bits zero", 32'h0000_00FF);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  initial begin
    #400_000;
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    step(4);
    rstN = 1'b1;
    step(1);
    testReset();
    testClearWins();
    testBringUp();
    testClockToggle();
    testSoftReset();
    testPowerEdges();
    testReadPort();
    finish();
  end

endmodule